// File: doc/BRIEF.md
# Split Set/Clear Interrupt Mask Register

This block keeps an interrupt mask that software changes through two write ports on a small register bus. A write to the set address turns on every mask bit that has a 1 in the data. A write to the clear address turns off every mask bit that has a 1 in the data. A 0 in the data never changes a bit. Software can therefore mask or unmask a single source without first reading the register, and it cannot disturb other sources while doing so.

The mask gates a vector of raw interrupt requests. A source whose mask bit is 1 is blocked. Only the low 11 lanes are implemented. The upper lanes read as zero, never pass a request, and ignore writes. While the standby input is high, bus writes are dropped and the mask keeps its value.

The register bus has no handshake. It accepts a write in every cycle, and a read returns data in the same cycle, so there is no back-pressure to manage. The request inputs and outputs are plain level signals.

Top module: `imask_regs`

## Requirements
- R1: A synchronous reset sets the mask to 0x000003FF. Reading the set address (0x0) afterwards returns 0x000003FF, so sources 9..0 are blocked and source 10 passes.
- R2: A write with `bus_we`=1 to address 0x0 sets every mask bit whose data bit is 1. Bits whose data bit is 0 keep their value. The result is visible from the next cycle.
- R3: A write with `bus_we`=1 to address 0x4 clears every mask bit whose data bit is 1. Bits whose data bit is 0 keep their value.
- R4: Bits 31..11 of read data and of `irq_masked` are always 0. Data bits 31..11 of any write have no effect.
- R5: Reading address 0x4, or any address other than 0x0, returns 0. A write to an address other than 0x0 or 0x4 leaves the mask unchanged.
- R6: For bits 10..0, `irq_masked` equals `irq_raw` AND NOT mask. It follows `irq_raw` in the same cycle, and it follows a mask change in the cycle after the write edge.
- R7: `irq_any` is 1 exactly when some bit of `irq_masked` is 1.
- R8: While `standby` is 1, writes to either address are ignored and the mask holds.
- R9: With `bus_we`=0 the mask does not change, whatever the address and data are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 4 | Byte address: 0x0 is the set register, 0x4 is the clear register |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| standby | input | 1 | When high, holds the mask and blocks writes |
| irq_raw | input | 32 | Raw interrupt requests |
| irq_masked | output | 32 | Requests that pass the mask |
| irq_any | output | 1 | OR of `irq_masked` |

## Verification
Read data, `irq_masked` and `irq_any` are combinational from the current mask and the current inputs, so they are due in the same cycle as the stimulus. The bench therefore drives on the falling edge and compares one nanosecond later, still before the rising edge. A write changes the mask at the next rising edge. The reference model applies that write only after it has seen that edge, so the effect is first expected in the following cycle's comparison, one cycle after the stimulus. Comparisons are suppressed until the model has seen a reset edge, and they run on every cycle after that.

// File: rtl/imask_pkg.sv
`timescale 1ns/1ps
package imask_pkg;
  // Which mask port a bus cycle targets
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_SET  = 2'd1,
    TGT_CLR  = 2'd2
  } tgt_e;
endpackage

// File: rtl/imask_decode.sv
`timescale 1ns/1ps
module imask_decode
  import imask_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter logic [ADDR_W-1:0] SET_ADDR = '0,
  parameter logic [ADDR_W-1:0] CLR_ADDR = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic              standby,
  output tgt_e              tgt,
  output logic              set_en,
  output logic              clr_en
);
  logic wr_ok;

  always_comb begin
    if (addr == SET_ADDR)      tgt = TGT_SET;
    else if (addr == CLR_ADDR) tgt = TGT_CLR;
    else                       tgt = TGT_NONE;
  end

  // standby freezes the mask: writes are dropped here
  assign wr_ok  = we & ~standby;
  assign set_en = wr_ok & (tgt == TGT_SET);
  assign clr_en = wr_ok & (tgt == TGT_CLR);
endmodule

// File: rtl/imask_store.sv
`timescale 1ns/1ps
module imask_store #(
  parameter int unsigned IMPL_W = 11,
  parameter logic [IMPL_W-1:0] RESET_MASK = 11'h3FF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IMPL_W-1:0] set_bits,
  input  logic [IMPL_W-1:0] clr_bits,
  output logic [IMPL_W-1:0] mask_q
);
  // One flop per lane; a set has priority over a clear on the same lane
  for (genvar i = 0; i < IMPL_W; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)              mask_q[i] <= RESET_MASK[i];
      else if (set_bits[i]) mask_q[i] <= 1'b1;
      else if (clr_bits[i]) mask_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/imask_gate.sv
`timescale 1ns/1ps
module imask_gate #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMPL_W = 11
) (
  input  logic [DATA_W-1:0] raw,
  input  logic [IMPL_W-1:0] mask,
  output logic [DATA_W-1:0] masked,
  output logic              any
);
  logic unused_raw_hi;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i < IMPL_W) begin : g_impl
      assign masked[i] = raw[i] & ~mask[i];
    end else begin : g_tie
      assign masked[i] = 1'b0;
    end
  end

  assign unused_raw_hi = &{1'b0, raw[DATA_W-1:IMPL_W]};
  assign any = |masked[IMPL_W-1:0];
endmodule

// File: rtl/imask_regs.sv
`timescale 1ns/1ps
module imask_regs
  import imask_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMPL_W = 11,
  parameter int unsigned ADDR_W = 4,
  parameter logic [ADDR_W-1:0] SET_ADDR = '0,
  parameter logic [ADDR_W-1:0] CLR_ADDR = 4,
  parameter logic [IMPL_W-1:0] RESET_MASK = 11'h3FF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              standby,
  input  logic [DATA_W-1:0] irq_raw,
  output logic [DATA_W-1:0] irq_masked,
  output logic              irq_any
);
  localparam int unsigned HI_W = DATA_W - IMPL_W;

  tgt_e              tgt;
  logic              set_en, clr_en;
  logic [IMPL_W-1:0] set_bits, clr_bits;
  logic [IMPL_W-1:0] mask_q;
  logic              unused_wdata_hi;

  imask_decode #(
    .ADDR_W  (ADDR_W),
    .SET_ADDR(SET_ADDR),
    .CLR_ADDR(CLR_ADDR)
  ) u_decode (
    .addr   (bus_addr),
    .we     (bus_we),
    .standby(standby),
    .tgt    (tgt),
    .set_en (set_en),
    .clr_en (clr_en)
  );

  assign set_bits = set_en ? bus_wdata[IMPL_W-1:0] : '0;
  assign clr_bits = clr_en ? bus_wdata[IMPL_W-1:0] : '0;
  assign unused_wdata_hi = &{1'b0, bus_wdata[DATA_W-1:IMPL_W]};

  imask_store #(
    .IMPL_W    (IMPL_W),
    .RESET_MASK(RESET_MASK)
  ) u_store (
    .clk     (clk),
    .rst     (rst),
    .set_bits(set_bits),
    .clr_bits(clr_bits),
    .mask_q  (mask_q)
  );

  imask_gate #(
    .DATA_W(DATA_W),
    .IMPL_W(IMPL_W)
  ) u_gate (
    .raw   (irq_raw),
    .mask  (mask_q),
    .masked(irq_masked),
    .any   (irq_any)
  );

  // Only the set address reads back the mask; the clear port reads as zero
  always_comb begin
    if (tgt == TGT_SET) bus_rdata = {{HI_W{1'b0}}, mask_q};
    else                bus_rdata = '0;
  end
endmodule

// File: rtl/imask_regs_chk.sv
`timescale 1ns/1ps
module imask_regs_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMPL_W = 11,
  parameter int unsigned ADDR_W = 4,
  parameter logic [ADDR_W-1:0] SET_ADDR = '0,
  parameter logic [ADDR_W-1:0] CLR_ADDR = 4,
  parameter logic [IMPL_W-1:0] RESET_MASK = 11'h3FF
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [IMPL_W-1:0] wdata_lo,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              standby,
  input logic [IMPL_W-1:0] raw_lo,
  input logic [DATA_W-1:0] irq_masked,
  input logic              irq_any,
  input logic [IMPL_W-1:0] mask_q
);
  p_reset_value_r1: assert property (@(posedge clk)
    rst |=> (mask_q == RESET_MASK));

  p_set_ones_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_we && !standby && bus_addr == SET_ADDR)
      |=> ((mask_q & $past(wdata_lo)) == $past(wdata_lo)));

  p_clear_ones_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_we && !standby && bus_addr == CLR_ADDR)
      |=> ((mask_q & $past(wdata_lo)) == '0));

  p_upper_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata[DATA_W-1:IMPL_W] == '0) && (irq_masked[DATA_W-1:IMPL_W] == '0));

  p_gate_r6: assert property (@(posedge clk) disable iff (rst)
    irq_masked[IMPL_W-1:0] == (raw_lo & ~mask_q));

  p_any_r7: assert property (@(posedge clk) disable iff (rst)
    irq_any == (|(raw_lo & ~mask_q)));

  p_standby_hold_r8: assert property (@(posedge clk) disable iff (rst)
    standby |=> $stable(mask_q));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!bus_we) |=> $stable(mask_q));
endmodule

bind imask_regs imask_regs_chk #(
  .DATA_W    (DATA_W),
  .IMPL_W    (IMPL_W),
  .ADDR_W    (ADDR_W),
  .SET_ADDR  (SET_ADDR),
  .CLR_ADDR  (CLR_ADDR),
  .RESET_MASK(RESET_MASK)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .wdata_lo  (bus_wdata[IMPL_W-1:0]),
  .bus_rdata (bus_rdata),
  .standby   (standby),
  .raw_lo    (irq_raw[IMPL_W-1:0]),
  .irq_masked(irq_masked),
  .irq_any   (irq_any),
  .mask_q    (mask_q)
);

// File: tb/imask_regs_tb.sv
`timescale 1ns/1ps
module imask_regs_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        standby = 1'b0;
  logic [31:0] irq_raw = '0;
  logic [31:0] irq_masked;
  logic        irq_any;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference model state
  logic [31:0] ref_mask = '0;
  bit          ref_ok = 0;

  always #2 clk = ~clk;

  imask_regs u_dut (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .standby   (standby),
    .irq_raw   (irq_raw),
    .irq_masked(irq_masked),
    .irq_any   (irq_any)
  );

  task automatic cmp32(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at falling edge, compare 1 ns later, model the rising edge
  task automatic step(input string tag, input bit r, input bit we,
                      input logic [3:0] a, input logic [31:0] d,
                      input bit sb, input logic [31:0] raw);
    logic [31:0] exp_rd, exp_m;
    @(negedge clk);
    rst = r; bus_we = we; bus_addr = a; bus_wdata = d;
    standby = sb; irq_raw = raw;
    #1;
    if (ref_ok && !r) begin
      exp_rd = (a == 4'h0) ? ref_mask : 32'h0;
      exp_m  = raw & ~ref_mask & 32'h0000_07FF;
      cmp32(tag, "bus_rdata", bus_rdata, exp_rd);
      cmp32("R6", "irq_masked", irq_masked, exp_m);
      cmp32("R7", "irq_any", {31'h0, irq_any}, {31'h0, |exp_m});
    end
    @(posedge clk);
    if (r) begin
      ref_mask = 32'h0000_03FF;
      ref_ok = 1;
    end else if (we && !sb) begin
      if (a == 4'h0) ref_mask = ref_mask | (d & 32'h0000_07FF);
      else if (a == 4'h4) ref_mask = ref_mask & ~(d & 32'h0000_07FF);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog run did not complete");
    finish_run();
  end

  initial begin
    // reset (R1)
    for (int i = 0; i < 3; i++) step("R1", 1, 0, 4'h0, 32'h0, 0, 32'h0);
    step("R1", 0, 0, 4'h0, 32'h0, 0, 32'hFFFF_FFFF);
    step("R1", 0, 0, 4'h0, 32'h0, 0, 32'h0000_0400);
    // upper write bits ignored (R4)
    step("R4", 0, 1, 4'h0, 32'hFFFF_F800, 0, 32'hFFFF_FFFF);
    step("R4", 0, 0, 4'h0, 32'h0, 0, 32'hFFFF_FFFF);
    // clear ones, zeros keep (R3)
    step("R3", 0, 1, 4'h4, 32'h0000_0005, 0, 32'h0000_0007);
    step("R3", 0, 1, 4'h4, 32'h0000_0000, 0, 32'h0000_0007);
    step("R3", 0, 0, 4'h0, 32'h0, 0, 32'h0000_0007);
    // set ones, zeros keep (R2)
    step("R2", 0, 1, 4'h0, 32'h0000_0401, 0, 32'h0000_0401);
    step("R2", 0, 1, 4'h0, 32'h0000_0000, 0, 32'h0000_0401);
    step("R2", 0, 0, 4'h0, 32'h0, 0, 32'h0000_07FF);
    // clear port reads zero, stray address ignored (R5)
    step("R5", 0, 0, 4'h4, 32'h0, 0, 32'h0);
    step("R5", 0, 1, 4'h8, 32'h0000_07FF, 0, 32'h0);
    step("R5", 0, 0, 4'h8, 32'h0, 0, 32'h0);
    step("R5", 0, 0, 4'h0, 32'h0, 0, 32'h0000_07FF);
    // standby blocks writes (R8)
    step("R8", 0, 1, 4'h4, 32'h0000_07FF, 1, 32'h0000_07FF);
    step("R8", 0, 1, 4'h0, 32'h0000_07FF, 1, 32'h0000_07FF);
    step("R8", 0, 0, 4'h0, 32'h0, 0, 32'h0000_07FF);
    step("R3", 0, 1, 4'h4, 32'h0000_07FF, 0, 32'h0000_07FF);
    step("R6", 0, 0, 4'h0, 32'h0, 0, 32'hFFFF_FFFF);
    // write strobe low (R9)
    step("R9", 0, 0, 4'h0, 32'h0000_07FF, 0, 32'h0000_0155);
    step("R9", 0, 0, 4'h0, 32'h0, 0, 32'h0000_02AA);
    // no raw request: any low (R7)
    step("R7", 0, 0, 4'h0, 32'h0, 0, 32'h0);
    // mixed traffic (R2 R3 R6 R7 R8)
    for (int i = 0; i < 200; i++) begin
      logic [31:0] rv;
      rv = $urandom;
      step("R2", 0, rv[0], rv[1] ? 4'h4 : (rv[2] ? 4'h0 : 4'hC),
           $urandom, rv[3] & rv[4], $urandom);
    end
    // reset from a modified mask (R1)
    step("R1", 0, 1, 4'h0, 32'h0000_0400, 0, 32'h0);
    step("R1", 1, 0, 4'h0, 32'h0, 0, 32'h0);
    step("R1", 0, 0, 4'h0, 32'h0, 0, 32'h0000_07FF);
    finish_run();
  end
endmodule